// File: doc/BRIEF.md
# Zero-Current Turn-On PWM for a Boost PFC Stage

This block drives the gate of a boost power-factor-correction switch that may run in discontinuous conduction. After each on-pulse the switch opens and the inductor current falls through zero. It then rings below zero against the capacitance of the switch node. The block does not restart at a fixed period boundary. It waits for the ringing current to come back up through zero, and it closes the switch at that moment. Every cycle therefore begins at the same zero-current point.

The on-pulse length is the commanded on-time, limited by a programmable ceiling. The ceiling keeps the duty below 100 % so that a sensing current transformer can reset. Near the AC zero crossing the control loop asks for almost full duty, and there the ceiling sets the pulse length. A blanking window after turn-off hides the polarity comparator from ringing at the switching edge. A maximum off-time timeout closes the switch even if no crossing arrives, which covers continuous conduction.

The states are `S_ON` (gate high), `S_OFF_NEG` (gate low, waiting for the blanking window to end and for the current to go negative) and `S_OFF_RISE` (gate low, waiting for a rising zero crossing). The transitions are as follows:
- `S_ON`→`S_OFF_NEG` when the on-time is reached.
- `S_OFF_NEG`→`S_OFF_RISE` when blanking has ended and the synchronized comparator reads negative.
- `S_OFF_NEG`→`S_ON` on timeout.
- `S_OFF_RISE`→`S_ON` on a rising comparator edge or on timeout.

Top module: `pfc_zcs_pwm`

## Requirements
- R1: While reset is asserted the gate output is low. Reset leaves the controller in `S_OFF_NEG` with its phase counter at zero.
- R2: A gate pulse lasts exactly `ton_cmd_i` clock cycles when that value is at most `ton_max_i`. A value of 0 gives a pulse of 1 cycle.
- R3: When `ton_cmd_i` exceeds `ton_max_i`, the pulse lasts `ton_max_i` cycles (at least 1).
- R4: `cur_pos_i` (1 = current positive, 0 = negative) passes through two synchronizing flip-flops before it is used. A rise driven during off-cycle r therefore closes the switch so that the off time is r+3 cycles, where the first gate-low cycle is index 0.
- R5: During the first `blank_i` off cycles the comparator is ignored. A negative excursion that ends before blanking expires, with s2 (the second synchronizer stage) already high again by off-cycle `blank_i`, does not arm the turn-on.
- R6: If the comparator is driven low at off-cycle n and high at off-cycle r, with max(`blank_i`, n+2) ≤ r+1, the switch closes after r+3 off cycles unless the timeout comes first.
- R7: The off time never exceeds `toff_max_i` cycles. A value of 0 acts as 1.
- R8: Comparator rising edges seen while the gate is on, or in `S_OFF_NEG`, do not change the pulse or start a new one.
- R9: When a zero crossing and the timeout fall in the same cycle, exactly one pulse starts. The off time equals both limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_pos_i | input | 1 | Asynchronous current-polarity comparator, 1 = positive |
| ton_cmd_i | input | CNT_W | Commanded on-time in cycles |
| ton_max_i | input | CNT_W | Maximum on-time (duty clamp) in cycles |
| blank_i | input | CNT_W | Off-time blanking length in cycles |
| toff_max_i | input | CNT_W | Maximum off-time before forced turn-on |
| gate_o | output | 1 | Switch gate drive, 1 = on |

## Verification
Two turn-on causes can land in the same cycle: a rising zero crossing and the off-time timeout. A directed case places the comparator rise so that r+3 equals `toff_max_i`. Random cases with fixed-seed placement of the ringing and timeout values produce further such coincidences. Each case is judged by checking three things: the off interval equals the common limit, a single pulse follows, and that pulse has the clamped on-time.

// File: rtl/pfc_zcs_pkg.sv
package pfc_zcs_pkg;
    typedef enum logic [1:0] {
        S_ON       = 2'd0,
        S_OFF_NEG  = 2'd1,
        S_OFF_RISE = 2'd2
    } zcs_state_t;
endpackage

// File: rtl/pfc_sync_edge.sv
module pfc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/pfc_ontime_calc.sv
module pfc_ontime_calc #(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] cmd_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic [CNT_W-1:0] len_o
);
    logic [CNT_W-1:0] clipped;

    always_comb begin
        clipped = (cmd_i > lim_i) ? lim_i : cmd_i;
        len_o   = (clipped == '0) ? CNT_W'(1) : clipped;
    end
endmodule

// File: rtl/pfc_phase_timer.sv
module pfc_phase_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_o <= '0;
        else if (clr_i)      cnt_o <= '0;
        else if (~&cnt_o)    cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/pfc_zcs_pwm.sv
module pfc_zcs_pwm
    import pfc_zcs_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cur_pos_i,
    input  logic [CNT_W-1:0] ton_cmd_i,
    input  logic [CNT_W-1:0] ton_max_i,
    input  logic [CNT_W-1:0] blank_i,
    input  logic [CNT_W-1:0] toff_max_i,
    output logic             gate_o
);
    localparam int EXT_W = CNT_W + 1;

    zcs_state_t       state, state_n;
    logic             pos_lvl, pos_rise;
    logic [CNT_W-1:0] on_len;
    logic [CNT_W-1:0] phase_cnt;
    logic             phase_clr;
    logic             blank_done;
    logic             off_timeout;

    pfc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cur_pos_i),
        .level_o (pos_lvl),
        .rise_o  (pos_rise)
    );

    pfc_ontime_calc #(.CNT_W(CNT_W)) u_ontime (
        .cmd_i (ton_cmd_i),
        .lim_i (ton_max_i),
        .len_o (on_len)
    );

    pfc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase_clr),
        .cnt_o (phase_cnt)
    );

    assign blank_done  = (phase_cnt >= blank_i);
    assign off_timeout = ({1'b0, phase_cnt} + EXT_W'(1)) >= {1'b0, toff_max_i};
    assign phase_clr   = (state == S_ON) != (state_n == S_ON);

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_ON: begin
                if (phase_cnt >= on_len - CNT_W'(1)) state_n = S_OFF_NEG;
            end
            S_OFF_NEG: begin
                if (off_timeout)                  state_n = S_ON;
                else if (blank_done && !pos_lvl)  state_n = S_OFF_RISE;
            end
            S_OFF_RISE: begin
                if (off_timeout || pos_rise)      state_n = S_ON;
            end
            default: state_n = S_OFF_NEG;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF_NEG;
        else        state <= state_n;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_o <= 1'b0;
        else        gate_o <= (state_n == S_ON);
    end
endmodule

// File: rtl/pfc_zcs_pwm_chk.sv
module pfc_zcs_pwm_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_o,
    input logic [CNT_W-1:0] ton_cmd_i,
    input logic [CNT_W-1:0] ton_max_i,
    input logic [CNT_W-1:0] blank_i,
    input logic [CNT_W-1:0] toff_max_i
);
    localparam int RW = CNT_W + 1;

    logic [RW-1:0] on_run, off_run;

    function automatic logic [RW-1:0] len_of(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] m);
        logic [CNT_W-1:0] v;
        v = (c > m) ? m : c;
        return (v == '0) ? RW'(1) : {1'b0, v};
    endfunction

    function automatic logic [RW-1:0] tmo_of(input logic [CNT_W-1:0] t);
        return (t == '0) ? RW'(1) : {1'b0, t};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_run  <= '0;
            off_run <= '0;
        end else begin
            on_run  <= gate_o  ? ((~&on_run)  ? on_run  + 1'b1 : on_run)  : '0;
            off_run <= !gate_o ? ((~&off_run) ? off_run + 1'b1 : off_run) : '0;
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !gate_o); // R1

    AST_ON_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_o) |-> ($past(on_run) + RW'(1) == len_of($past(ton_cmd_i), $past(ton_max_i)))); // R3

    AST_OFF_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_o |-> (off_run < tmo_of(toff_max_i))); // R7

    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> (($past(off_run) + RW'(1) == tmo_of($past(toff_max_i))) ||
                           ($past(off_run) >= {1'b0, $past(blank_i)} + RW'(1)))); // R5
endmodule

bind pfc_zcs_pwm pfc_zcs_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_o     (gate_o),
    .ton_cmd_i  (ton_cmd_i),
    .ton_max_i  (ton_max_i),
    .blank_i    (blank_i),
    .toff_max_i (toff_max_i)
);

// File: tb/pfc_zcs_pwm_tb.sv
`timescale 1ns/1ps
module pfc_zcs_pwm_tb;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cur_pos = 1'b1;
    logic [W-1:0] ton_cmd = 10'd8, ton_max = 10'd20, blank = 10'd4, toff_max = 10'd30;
    logic         gate;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pfc_zcs_pwm #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_pos_i  (cur_pos),
        .ton_cmd_i  (ton_cmd),
        .ton_max_i  (ton_max),
        .blank_i    (blank),
        .toff_max_i (toff_max),
        .gate_o     (gate)
    );

    function automatic int exp_on(input int c, input int m);
        int v;
        v = (c > m) ? m : c;
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int exp_off(input int b, input int t, input bit neg, input int n, input int r);
        int tm, st, res;
        tm  = (t == 0) ? 1 : t;
        res = tm;
        st  = (b > n + 2) ? b : n + 2;
        if (neg && st <= r + 1 && r + 3 < res) res = r + 3;
        return res;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        int on_len, off_len, eo, ef, n, r, wait_cnt;
        bit neg;
        string tag;
        void'($urandom(32'd4242));

        repeat (4) @(negedge clk);
        check("R1 gate low in reset", int'(gate), 0);
        @(negedge clk);
        check("R1 gate low in reset", int'(gate), 0);
        rst_n = 1'b1;

        wait_cnt = 0;
        while (!gate && wait_cnt < 200) begin
            @(negedge clk);
            wait_cnt++;
        end

        for (int it = 0; it < 300; it++) begin
            // ON index 0: program this cycle's settings
            neg = 1'b1; n = 0; r = 1;
            unique case (it)
                0: begin ton_cmd = 5;  ton_max = 10; blank = 2;  toff_max = 40; n = 0; r = 1;  end
                1: begin ton_cmd = 30; ton_max = 12; blank = 3;  toff_max = 60; n = 3; r = 10; end
                2: begin ton_cmd = 0;  ton_max = 9;  blank = 20; toff_max = 50; n = 2; r = 5;  end
                3: begin ton_cmd = 7;  ton_max = 7;  blank = 4;  toff_max = 20; n = 4; r = 17; end
                4: begin ton_cmd = 3;  ton_max = 40; blank = 5;  toff_max = 7;  neg = 1'b0;   end
                5: begin ton_cmd = 1;  ton_max = 0;  blank = 2;  toff_max = 0;  neg = 1'b0;   end
                6: begin ton_cmd = 9;  ton_max = 50; blank = 8;  toff_max = 30; n = 2; r = 7;  end
                7: begin ton_cmd = 9;  ton_max = 50; blank = 9;  toff_max = 30; n = 2; r = 7;  end
                default: begin
                    ton_cmd  = W'($urandom_range(0, 60));
                    ton_max  = W'($urandom_range(1, 50));
                    blank    = W'($urandom_range(2, 20));
                    toff_max = W'($urandom_range(0, 120));
                    neg      = ($urandom_range(0, 4) != 0);
                    n        = $urandom_range(0, 30);
                    r        = n + 1 + $urandom_range(0, 40);
                end
            endcase
            cur_pos = 1'b1;
            eo = exp_on(int'(ton_cmd), int'(ton_max));
            ef = exp_off(int'(blank), int'(toff_max), neg, n, r);

            on_len = 1;
            @(negedge clk);
            while (gate && on_len < 300) begin
                on_len++;
                @(negedge clk);
            end
            if (int'(ton_cmd) > int'(ton_max)) check("R3 clamped on-time (R8 edge in ON)", on_len, eo);
            else                               check("R2 commanded on-time (R8 edge in ON)", on_len, eo);

            off_len = 0;
            while (off_len < 300) begin
                if (neg && off_len == n) cur_pos = 1'b0;
                if (neg && off_len == r) cur_pos = 1'b1;
                @(negedge clk);
                off_len++;
                if (gate) break;
            end

            if (neg && r + 3 == ef && ef == ((toff_max == 0) ? 1 : int'(toff_max)))
                tag = "R9 crossing and timeout together";
            else if (neg && r + 3 == ef)
                tag = "R6 R4 zero-crossing turn-on";
            else if (neg && r + 1 < int'(blank))
                tag = "R5 crossing hidden by blanking";
            else
                tag = "R7 off-time timeout";
            check(tag, off_len, ef);
        end

        done = 1'b1;
        finish_run();
    end
endmodule